// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block holds one status byte for each finished transmission until the host collects it. A transmit engine sends a completion report as a single-cycle push. The report carries four flags: interrupt requested, jabber, underrun and maximum collisions. The block queues these bytes oldest first. The host reads the head byte from `status_byte` and removes it with a write strobe on the same port.

While the head byte asks for attention, the block raises a transmit-complete event for the main status word. If a report arrives when every slot is taken, the report is dropped and the newest stored byte is marked with an overflow bit. A jabber or underrun report locks the transmitter. The lock holds until a transmit reset, and that reset also empties the queue.

Top module: `tx_done_fifo`

## Requirements
- R1: A stored byte reads as bit 7 = 1 (complete), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow, and bits 1:0 = 0.
- R2: Up to DEPTH reports (default 4) are held and leave in the order they arrived.
- R3: A host write removes the head byte. A host write while the queue is empty changes nothing.
- R4: `status_byte` reads 0 while the queue is empty.
- R5: A push into a full queue with no removal in the same cycle is dropped. It sets bit 2 of the newest stored byte and leaves every other stored byte unchanged.
- R6: When the queue is full, a push and a host write in the same cycle both take effect: the head leaves and the new report is stored with bit 2 clear.
- R7: A push with jabber or underrun set raises `tx_locked` from the next cycle on. This holds even if the push is dropped, and the lock stays up until a transmit reset.
- R8: `tx_reset` empties the queue and clears `tx_locked`. It takes precedence over a push or a host write in the same cycle.
- R9: `complete_evt` is high exactly when the queue is not empty and the head byte has any of bits 6 to 2 set.
- R10: After reset the queue is empty, `tx_locked` is low and `complete_evt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Completion report strobe from the transmit engine |
| push_intr | input | 1 | Report flag: interrupt on success requested |
| push_jabber | input | 1 | Report flag: jabber error |
| push_underrun | input | 1 | Report flag: underrun |
| push_maxcoll | input | 1 | Report flag: maximum collisions reached |
| host_wr | input | 1 | Host write to the status port; removes the head byte |
| tx_reset | input | 1 | Transmit reset command; empties the queue and clears the lock |
| status_byte | output | 8 | Head status byte, or 0 when empty |
| complete_evt | output | 1 | Transmit-complete event for the main status word |
| tx_locked | output | 1 | Transmitter held off until a transmit reset |

## Verification
The bench builds the block with its default depth of four entries. With that depth, a full queue, a dropped report with its overflow mark, and a push and removal landing on a full queue are each reached within a handful of reports. A reference queue inside the bench predicts every head byte, so the order, the flag positions and the event level are all compared after each cycle. The lock and the transmit-reset precedence are exercised with reports that are dropped as well as reports that are stored.

// File: rtl/tx_done_fifo.sv
module tx_done_fifo #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_valid,
  input  logic       push_intr,
  input  logic       push_jabber,
  input  logic       push_underrun,
  input  logic       push_maxcoll,
  input  logic       host_wr,
  input  logic       tx_reset,
  output logic [7:0] status_byte,
  output logic       complete_evt,
  output logic       tx_locked
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [4:0]    mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;

  logic empty, full, pop, accept, drop;
  logic [4:0] head_e;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign pop    = host_wr && !empty;
  assign accept = push_valid && (!full || pop);
  assign drop   = push_valid && full && !pop;
  assign head_e = mem[head];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] prv(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      tx_locked <= 1'b0;
    end else if (tx_reset) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      tx_locked <= 1'b0;
    end else begin
      if (pop)    head <= nxt(head);
      if (accept) tail <= nxt(tail);
      count <= count + CW'(accept) - CW'(pop);
      if (push_valid && (push_jabber || push_underrun)) tx_locked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!tx_reset) begin
      if (accept)
        mem[tail] <= {push_intr, push_jabber, push_underrun, push_maxcoll, 1'b0};
      else if (drop)
        mem[prv(tail)][0] <= 1'b1;
    end
  end

  assign status_byte  = empty ? 8'h00 : {1'b1, head_e, 2'b00};
  assign complete_evt = !empty && (head_e != 5'b0);
endmodule

// File: rtl/tx_done_fifo_chk.sv
module tx_done_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       push_valid,
  input logic       push_jabber,
  input logic       push_underrun,
  input logic       tx_reset,
  input logic [7:0] status_byte,
  input logic       complete_evt,
  input logic       tx_locked
);
  assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[1:0] == 2'b00);

  assert_nonzero_complete_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte != 8'h00) |-> status_byte[7]);

  assert_evt_needs_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    complete_evt |-> (status_byte[7] && status_byte[6:2] != 5'b0));

  assert_lock_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && (push_jabber || push_underrun) && !tx_reset) |=> tx_locked);

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_locked && !tx_reset) |=> tx_locked);

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (!tx_locked && status_byte == 8'h00 && !complete_evt));
endmodule

bind tx_done_fifo tx_done_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_jabber(push_jabber),
  .push_underrun(push_underrun), .tx_reset(tx_reset), .status_byte(status_byte),
  .complete_evt(complete_evt), .tx_locked(tx_locked)
);

// File: tb/sim_tx_done_fifo.sv
module sim_tx_done_fifo;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_intr = 0, push_jabber = 0, push_underrun = 0, push_maxcoll = 0;
  logic host_wr = 0, tx_reset = 0;
  logic [7:0] status_byte;
  logic complete_evt, tx_locked;

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  logic exp_lock = 0;

  always #5 clk = ~clk;

  tx_done_fifo #(.DEPTH(4)) u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_head();
    return (exp_q.size() == 0) ? 8'h00 : exp_q[0];
  endfunction

  task automatic monitor(input string req);
    logic [7:0] h = exp_head();
    chk({req, " head"}, status_byte, h);
    chk("R9 event", {7'b0, complete_evt}, {7'b0, (h != 8'h00) && (h[6:2] != 5'b0)});
    chk("R7 lock", {7'b0, tx_locked}, {7'b0, exp_lock});
  endtask

  // f = {intr, jabber, underrun, maxcoll}
  task automatic step(input logic p, input logic [3:0] f, input logic w, input logic r,
                      input string req);
    bit was_full, did_pop;
    if (w) chk({req, " pre-pop"}, status_byte, exp_head());
    push_valid = p; {push_intr, push_jabber, push_underrun, push_maxcoll} = f;
    host_wr = w; tx_reset = r;
    @(posedge clk); #1;
    push_valid = 0; host_wr = 0; tx_reset = 0;
    {push_intr, push_jabber, push_underrun, push_maxcoll} = 4'b0;
    if (r) begin
      exp_q.delete(); exp_lock = 0;
    end else begin
      was_full = (exp_q.size() == 4);
      did_pop = w && exp_q.size() > 0;
      if (did_pop) void'(exp_q.pop_front());
      if (p) begin
        if (was_full && !did_pop) exp_q[exp_q.size()-1][2] = 1'b1;
        else exp_q.push_back({1'b1, f, 3'b000});
        if (f[2] || f[1]) exp_lock = 1;
      end
    end
    @(negedge clk);
    monitor(req);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    monitor("R10");
    chk("R4 empty reads zero", status_byte, 8'h00);
    step(0, 4'b0, 1, 0, "R3 pop empty");
    // ordering and layout
    step(1, 4'b1000, 0, 0, "R1");
    step(1, 4'b0001, 0, 0, "R1");
    step(1, 4'b0000, 0, 0, "R2");
    step(1, 4'b1001, 0, 0, "R2");
    chk("R1 intr byte", status_byte, 8'hC0);
    repeat (4) step(0, 4'b0, 1, 0, "R2 order");
    chk("R4 empty after drain", status_byte, 8'h00);
    // overflow
    step(1, 4'b0001, 0, 0, "R5");
    step(1, 4'b0000, 0, 0, "R5");
    step(1, 4'b1000, 0, 0, "R5");
    step(1, 4'b0000, 0, 0, "R5");
    step(1, 4'b1001, 0, 0, "R5 drop");
    step(1, 4'b1000, 0, 0, "R5 drop again");
    repeat (3) step(0, 4'b0, 1, 0, "R5 drain");
    chk("R5 newest has overflow", status_byte, 8'h84);
    step(0, 4'b0, 1, 0, "R5 drain");
    // simultaneous push and pop on full
    repeat (4) step(1, 4'b0001, 0, 0, "R6 fill");
    step(1, 4'b1000, 1, 0, "R6 push+pop");
    repeat (3) step(0, 4'b0, 1, 0, "R6 drain");
    chk("R6 new entry no overflow", status_byte, 8'hC0);
    step(0, 4'b0, 1, 0, "R6 drain");
    // lock
    step(1, 4'b0100, 0, 0, "R7 jabber");
    step(1, 4'b0000, 0, 0, "R7 sticky");
    step(0, 4'b0, 1, 0, "R7 sticky pop");
    step(0, 4'b0, 1, 0, "R7 sticky pop");
    step(0, 4'b0, 0, 1, "R8 reset");
    step(1, 4'b0010, 0, 0, "R7 underrun");
    step(1, 4'b0000, 0, 0, "R8 fill");
    step(1, 4'b1000, 1, 1, "R8 reset precedence");
    chk("R8 empty after reset", status_byte, 8'h00);
    // dropped error report still locks
    repeat (4) step(1, 4'b0000, 0, 0, "R7 fill");
    chk("R9 plain entry no event", {7'b0, complete_evt}, 8'h00);
    step(1, 4'b0010, 0, 0, "R7 dropped underrun");
    repeat (4) step(0, 4'b0, 1, 0, "R5 drain");
    step(0, 4'b0, 0, 1, "R8 reset");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule